// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block converts a three-level PWM command into the two gate enables of a synchronous buck half-bridge. It is placed after an external comparator that classifies the PWM line as low, high or floating and reports supply health. The sequencer gates the stage on that supply flag and on an enable input. It shuts both switches off when the PWM line floats for too long. It holds both switches off at start-up until a real high pulse arrives, so that a pre-charged output is not discharged. It also inserts break-before-make dead time on every handover between the switches.

All three inputs pass through a two-flop synchroniser. All decisions are made in the clock domain of `clk`, and timing values are given as parameters counted in clock cycles.

Top module: `hb_gate_seq`

## Requirements
- R1: When `rst` is high at a clock edge, both gate outputs and `active_o` go low and the start-up hold is re-armed.
- R2: Each input passes through two flops before it is used, so a change on `enable_i` shows on `active_o` on the third rising edge after it. The PWM code is decoded as 2'b00 = low, 2'b01 = high, and 2'b10 or 2'b11 = floating.
- R3: While the synchronised supply flag is low, both gates stay off and `active_o` is low, whatever the PWM and enable inputs do.
- R4: While the synchronised enable is low, both gates stay off and `active_o` is low.
- R5: Once supply and enable are both high, both gates stay off until the PWM code reads high for at least MIN_ON_CYC consecutive cycles. A low command in this phase does not turn on the low-side gate.
- R6: A high pulse shorter than MIN_ON_CYC cycles does not end the start-up hold.
- R7: After the hold ends, a high command selects the high-side gate and a low command selects the low-side gate.
- R8: A floating code lasting HOLDOFF_CYC consecutive cycles or more turns both gates off. A shorter floating interval keeps the previous gate selection.
- R9: The start-up hold is re-armed only by enable going low or the supply flag dropping. After either one, a low command does not turn on the low-side gate until a new qualified high pulse arrives.
- R10: The two gate outputs are never high in the same cycle.
- R11: A gate turns on only after both gates have been off for at least DEAD_CYC consecutive cycles.
- R12: `active_o` is high exactly when the synchronised supply and enable were both high on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply above lockout level, from an external comparator |
| enable_i | input | 1 | Stage enable |
| pwm_code_i | input | 2 | Classified PWM level: 00 low, 01 high, 10/11 floating |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |
| active_o | output | 1 | Stage enabled and supply good |

## Verification
Two functions can act in the same cycle: the single-shot start-up hold and the dead-time handover. The pulse that qualifies the hold also requests the high side, and the low command that follows asks for a handover while the high side has only just turned on. The bench drives a high pulse of exactly MIN_ON_CYC cycles into the hold and then returns to low at once. A free-running monitor measures every off interval in front of each turn-on and flags any overlap, and the bench checks that the low side ends up driven. A pulse one cycle shorter must leave both gates off.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  typedef enum logic [1:0] {LVL_LO, LVL_HI, LVL_MID} lvl_t;
  typedef enum logic [1:0] {DRV_OFF, DRV_HS, DRV_LS} drv_t;
  typedef enum logic [1:0] {ST_LOCK, ST_HOLD, ST_RUN} st_t;

  function automatic lvl_t decode_pwm(input logic [1:0] code);
    case (code)
      2'b00:   return LVL_LO;
      2'b01:   return LVL_HI;
      default: return LVL_MID;
    endcase
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hb_pwm_qual.sv
module hb_pwm_qual
  import hb_gate_pkg::*;
#(
  parameter int HOLDOFF_CYC = 10,
  parameter int MIN_ON_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] code,
  output lvl_t       lvl,
  output logic       hi_qual,
  output logic       mid_trip
);
  localparam int HW = $clog2(HOLDOFF_CYC + 1);
  localparam int QW = $clog2(MIN_ON_CYC + 1);

  logic [HW-1:0] mid_cnt;
  logic [QW-1:0] hi_cnt;

  assign lvl      = decode_pwm(code);
  assign mid_trip = (lvl == LVL_MID) && (mid_cnt >= HW'(HOLDOFF_CYC - 1));
  assign hi_qual  = (lvl == LVL_HI)  && (hi_cnt  >= QW'(MIN_ON_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_cnt <= '0;
      hi_cnt  <= '0;
    end else begin
      if (lvl != LVL_MID)                    mid_cnt <= '0;
      else if (mid_cnt != HW'(HOLDOFF_CYC)) mid_cnt <= mid_cnt + 1'b1;
      if (lvl != LVL_HI)                     hi_cnt <= '0;
      else if (hi_cnt != QW'(MIN_ON_CYC))   hi_cnt <= hi_cnt + 1'b1;
    end
  end

  generate
    if (HOLDOFF_CYC > 1) begin : g_mid_chk
      // R8: a shutdown trip needs a floating level on the previous cycle too
      a_r8_trip_needs_run: assert property (@(posedge clk) disable iff (rst)
        mid_trip |-> ($past(lvl) == LVL_MID));
    end
    if (MIN_ON_CYC > 1) begin : g_hi_chk
      // R6: qualification needs a high level on the previous cycle too
      a_r6_qual_needs_run: assert property (@(posedge clk) disable iff (rst)
        hi_qual |-> ($past(lvl) == LVL_HI));
    end
  endgenerate
endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
  import hb_gate_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  drv_t want,
  output logic hs_q,
  output logic ls_q
);
  localparam int DW = $clog2(DEAD_CYC + 1);

  logic [DW-1:0] off_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
      off_cnt <= '0;
    end else if (hs_q || ls_q) begin
      off_cnt <= '0;
      if (want != DRV_HS) hs_q <= 1'b0;
      if (want != DRV_LS) ls_q <= 1'b0;
    end else begin
      if (off_cnt != DW'(DEAD_CYC)) off_cnt <= off_cnt + 1'b1;
      if (off_cnt >= DW'(DEAD_CYC - 1)) begin
        hs_q <= (want == DRV_HS);
        ls_q <= (want == DRV_LS);
      end
    end
  end

  a_r10_never_both: assert property (@(posedge clk) disable iff (rst)
    !(hs_q && ls_q));
  a_r11_no_swap_hs: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_q) |-> !$past(ls_q));
  a_r11_no_swap_ls: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_q) |-> !$past(hs_q));
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_gate_pkg::*;
#(
  parameter int HOLDOFF_CYC = 10,
  parameter int MIN_ON_CYC  = 4,
  parameter int DEAD_CYC    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok_i,
  input  logic       enable_i,
  input  logic [1:0] pwm_code_i,
  output logic       hs_gate_o,
  output logic       ls_gate_o,
  output logic       active_o
);
  localparam int SW = 4;

  logic [SW-1:0] sync_q;
  logic          sup_s, en_s, go;
  lvl_t          lvl;
  logic          hi_qual, mid_trip, run_now;
  st_t           state, state_d;
  drv_t          want_q, want_d;

  hb_sync #(.W(SW)) u_sync (
    .clk(clk), .rst(rst),
    .d({supply_ok_i, enable_i, pwm_code_i}),
    .q(sync_q)
  );

  assign sup_s = sync_q[3];
  assign en_s  = sync_q[2];
  assign go    = sup_s && en_s;

  hb_pwm_qual #(.HOLDOFF_CYC(HOLDOFF_CYC), .MIN_ON_CYC(MIN_ON_CYC)) u_qual (
    .clk(clk), .rst(rst), .code(sync_q[1:0]),
    .lvl(lvl), .hi_qual(hi_qual), .mid_trip(mid_trip)
  );

  always_comb begin
    state_d = state;
    if (!go) state_d = ST_LOCK;
    else begin
      case (state)
        ST_LOCK: state_d = ST_HOLD;
        ST_HOLD: if (hi_qual) state_d = ST_RUN;
        default: state_d = ST_RUN;
      endcase
    end
  end

  assign run_now = go && ((state == ST_RUN) || ((state == ST_HOLD) && hi_qual));

  always_comb begin
    want_d = DRV_OFF;
    if (run_now) begin
      case (lvl)
        LVL_HI:  want_d = DRV_HS;
        LVL_LO:  want_d = DRV_LS;
        default: want_d = mid_trip ? DRV_OFF : want_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_LOCK;
      want_q   <= DRV_OFF;
      active_o <= 1'b0;
    end else begin
      state    <= state_d;
      want_q   <= want_d;
      active_o <= go;
    end
  end

  hb_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk(clk), .rst(rst), .want(want_q),
    .hs_q(hs_gate_o), .ls_q(ls_gate_o)
  );

  // R3/R4: two cycles of lockout leave both gates off
  a_r3_lockout_off: assert property (@(posedge clk) disable iff (rst)
    (!go && !$past(go)) |=> (!hs_gate_o && !ls_gate_o));
  // R5: during the start-up hold the low side is never requested
  a_r5_hold_no_ls: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |=> (want_q != DRV_LS));
  // R9: leaving lockout always passes through the hold state
  a_r9_rearm_path: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_LOCK && state != ST_LOCK) |-> (state == ST_HOLD));
endmodule

// File: tb/hb_gate_seq_tb_top.sv
module hb_gate_seq_tb_top;
  localparam int HOLD  = 10;
  localparam int MINON = 4;
  localparam int DEAD  = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sup = 1'b0;
  logic       en  = 1'b0;
  logic [1:0] code = 2'b00;
  logic       hs, ls, act;

  int checks = 0;
  int errors = 0;
  int cnt_hs, cnt_ls, cnt_off;
  int offrun = 0;
  int overlap_viol = 0;
  int dead_viol = 0;
  int turn_ons = 0;
  logic prev_hs = 1'b0;
  logic prev_ls = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  hb_gate_seq #(.HOLDOFF_CYC(HOLD), .MIN_ON_CYC(MINON), .DEAD_CYC(DEAD)) dut_i (
    .clk(clk), .rst(rst), .supply_ok_i(sup), .enable_i(en), .pwm_code_i(code),
    .hs_gate_o(hs), .ls_gate_o(ls), .active_o(act)
  );

  // free-running monitor for R10 and R11
  always @(negedge clk) begin
    if (!rst) begin
      if (hs && ls) overlap_viol++;
      if ((hs && !prev_hs) || (ls && !prev_ls)) begin
        turn_ons++;
        if (offrun < DEAD) dead_viol++;
      end
      if (!hs && !ls) offrun++; else offrun = 0;
    end
    prev_hs = hs;
    prev_ls = ls;
  end

  task automatic check(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch(input int n);
    repeat (n) begin
      @(negedge clk);
      if (hs) cnt_hs++;
      if (ls) cnt_ls++;
      if (!hs && !ls) cnt_off++;
    end
  endtask

  task automatic clr();
    cnt_hs = 0; cnt_ls = 0; cnt_off = 0;
  endtask

  task automatic t_reset();
    rst = 1'b1; sup = 1'b1; en = 1'b1; code = 2'b01;
    cyc(4);
    check("R1 hs after reset", hs, 0);
    check("R1 ls after reset", ls, 0);
    check("R1 active after reset", act, 0);
    sup = 1'b0; en = 1'b0; code = 2'b00;
    cyc(1);
    rst = 1'b0;
    cyc(4);
  endtask

  task automatic t_lockout();
    en = 1'b1; clr();
    repeat (5) begin code = 2'b01; watch(3); code = 2'b00; watch(3); end
    check("R3 hs on under lockout", cnt_hs, 0);
    check("R3 ls on under lockout", cnt_ls, 0);
    check("R3 active under lockout", act, 0);
  endtask

  task automatic t_prebias();
    sup = 1'b1; en = 1'b1; code = 2'b00;
    cyc(8); clr(); watch(10);
    check("R5 ls during hold", cnt_ls, 0);
    check("R12 active with supply and enable", act, 1);
    code = 2'b01; clr(); watch(MINON - 1);
    code = 2'b00; watch(12);
    check("R6 short pulse hs", cnt_hs, 0);
    check("R6 short pulse ls", cnt_ls, 0);
    code = 2'b01; clr(); watch(MINON);
    code = 2'b00; watch(12);
    check("R5 qualified pulse drives hs", (cnt_hs > 0) ? 1 : 0, 1);
    check("R7 low after release drives ls", ls, 1);
  endtask

  task automatic t_run();
    code = 2'b01; cyc(8);
    check("R7 high cmd hs", hs, 1);
    check("R7 high cmd ls", ls, 0);
    code = 2'b00; cyc(8);
    check("R7 low cmd ls", ls, 1);
    check("R7 low cmd hs", hs, 0);
  endtask

  task automatic t_float_short();
    clr();
    code = 2'b10; watch(HOLD - 1);
    code = 2'b00; watch(8);
    check("R8 short float keeps ls", cnt_off, 0);
    code = 2'b01; cyc(8); clr();
    code = 2'b11; watch(HOLD - 1);
    code = 2'b01; watch(8);
    check("R8 short float keeps hs", cnt_off, 0);
  endtask

  task automatic t_float_long();
    code = 2'b11; cyc(HOLD + 6);
    check("R8 long float (code 11) hs", hs, 0);
    check("R2 long float (code 11) ls", ls, 0);
    code = 2'b00; cyc(8);
    check("R8 float does not rearm hold", ls, 1);
    code = 2'b10; cyc(HOLD + 6);
    check("R2 long float (code 10) ls", ls, 0);
    code = 2'b00; cyc(8);
  endtask

  task automatic t_rearm_enable();
    en = 1'b0;
    cyc(2);
    check("R2 active held by sync", act, 1);
    cyc(1);
    check("R2 active drops on third edge", act, 0);
    cyc(4);
    check("R4 enable low hs", hs, 0);
    check("R4 enable low ls", ls, 0);
    en = 1'b1; clr(); watch(12);
    check("R9 enable rearms hold", cnt_ls, 0);
    code = 2'b01; cyc(8);
    check("R9 release after rearm", hs, 1);
  endtask

  task automatic t_rearm_supply();
    sup = 1'b0; cyc(4); clr();
    repeat (3) begin code = 2'b00; watch(4); code = 2'b01; watch(4); end
    check("R3 supply drop hs", cnt_hs, 0);
    check("R3 supply drop ls", cnt_ls, 0);
    check("R12 active low on supply drop", act, 0);
    sup = 1'b1; code = 2'b00; cyc(4); clr(); watch(12);
    check("R9 supply drop rearms hold", cnt_ls, 0);
    code = 2'b01; watch(MINON); code = 2'b00; cyc(10);
    check("R7 ls after second release", ls, 1);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lockout();
    t_prebias();
    t_run();
    t_float_short();
    t_float_long();
    t_rearm_enable();
    t_rearm_supply();
    check("R10 overlap cycles", overlap_viol, 0);
    check("R11 short dead intervals", dead_viol, 0);
    check("R11 turn-ons observed", (turn_ons > 4) ? 1 : 0, 1);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule